// File: doc/BRIEF.md
# Privilege Mode and Exception Entry Sequencer

This block keeps the one-bit privilege mode of a small core and carries out the hardware side of exception entry and handler return. Each cycle the core may present one decoded instruction: its PC, a small operation code, a protected-instruction flag, and any fault the datapath detected while executing it. An external interrupt line may be raised at any time. The block decides whether the instruction executes or is replaced by an exception. On an exception it saves the resume PC and the prior mode, enters kernel mode, masks interrupts, and issues a redirect to the handler address. That address is read from an internal table indexed by the exception number.

The resume PC depends on the class of exception. A fault saves the PC of the failing instruction so that it runs again. A system-call trap saves the address after it. An interrupt suppresses the instruction presented in that cycle and saves its PC, so every instruction still runs exactly once. A protected instruction issued from user mode does not execute and becomes a fault. The handler table is loaded through a valid/ready configuration port that accepts writes only in kernel mode. In user mode `cfg_ready` is low, and a requester must hold `cfg_valid`, `cfg_idx` and `cfg_addr` steady until the port accepts them.

Top module: `priv_exc_seq`

## Requirements
- R1: After reset the mode is kernel (`mode_kernel`=1), interrupts are masked (`irq_en`=0), no interrupt is pending, and `redirect_valid` is 0.
- R2: Mode encoding is 1 = kernel, 0 = user. The mode rises from user to kernel only through exception entry. A set-mode instruction (`instr_op`=2) executed in kernel mode writes `instr_arg` into the mode one cycle later.
- R3: Protected operations are set-mode (2), set-interrupt-enable (3), return (4), and any instruction with `instr_priv`=1. Issued in user mode, such an instruction changes neither mode nor interrupt enable. It raises a fault with vector 6 instead. In kernel mode it raises no exception.
- R4: On exception entry, the cycle after the exception cycle shows `mode_kernel`=1, `irq_en`=0, `saved_mode` equal to the mode before entry, `exc_vec` equal to the exception number, and a one-cycle `redirect_valid` pulse whose `redirect_pc` is the table entry for that number.
- R5: A datapath fault (`fault_valid` with `fault_vec`) uses `fault_vec` as its exception number and saves the faulting instruction's own PC in `epc`.
- R6: A system-call instruction (`instr_op`=1) traps with vector 128 and saves `instr_pc`+4 in `epc`, from either mode.
- R7: An interrupt is taken only in a cycle with `instr_valid`=1 and `irq_en`=1. It uses vector 32, suppresses that instruction, and saves its PC in `epc`.
- R8: When causes coincide, one exception is taken, in this priority order: privilege fault first, then datapath fault, then trap, then interrupt.
- R9: A request on `irq` that is not taken is held (`irq_pending`=1) while masked. It is taken at the first valid instruction after the mask is lifted, and then `irq_pending` clears.
- R10: A return instruction (`instr_op`=4) in kernel mode restores the mode from `saved_mode` and redirects to `epc` one cycle later. It leaves `irq_en` unchanged.
- R11: A table write happens when `cfg_valid` and `cfg_ready` are both high. `cfg_ready` equals the kernel mode bit, so a write offered in user mode leaves the table unchanged.
- R12: A set-interrupt-enable instruction (`instr_op`=3) executed in kernel mode writes `instr_arg` into `irq_en` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_pc | input | PC_W | PC of the presented instruction |
| instr_op | input | 3 | 0 plain, 1 system call, 2 set mode, 3 set interrupt enable, 4 return |
| instr_arg | input | 1 | Operand bit for set-mode and set-interrupt-enable |
| instr_priv | input | 1 | Instruction is otherwise protected (for example, device access) |
| fault_valid | input | 1 | Datapath fault on the presented instruction |
| fault_vec | input | VEC_W | Exception number of the datapath fault |
| irq | input | 1 | External interrupt request pulse |
| cfg_valid | input | 1 | Table write offered |
| cfg_ready | output | 1 | Table write can be accepted (kernel mode) |
| cfg_idx | input | VEC_W | Table entry to write |
| cfg_addr | input | PC_W | Handler address to store |
| mode_kernel | output | 1 | Current mode, 1 = kernel |
| irq_en | output | 1 | Interrupts unmasked |
| irq_pending | output | 1 | Interrupt request waiting |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Handler address or return address |
| exc_vec | output | VEC_W | Number of the last exception taken |
| epc | output | PC_W | Saved resume PC |
| saved_mode | output | 1 | Mode saved at the last exception entry |

## Verification
Faults, system-call traps and interrupts can all arrive in the same cycle, and a privilege violation can coincide with a datapath fault. The bench provokes this by presenting one instruction that is a system call, carries a datapath fault, and arrives with an interrupt pulse. It also presents a user-mode set-mode instruction that carries a datapath fault. The outcome is judged from the exception number and saved PC of the single redirect. The losing interrupt must remain pending and must be taken only once the handler unmasks interrupts.

// File: rtl/priv_seq_pkg.sv
package priv_seq_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_SYSCALL = 3'd1,
    OP_SETMODE = 3'd2,
    OP_SETIE   = 3'd3,
    OP_RETURN  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_FAULT = 2'd1,
    CLS_TRAP  = 2'd2,
    CLS_IRQ   = 2'd3
  } cls_e;

  localparam logic MODE_USER   = 1'b0;
  localparam logic MODE_KERNEL = 1'b1;
endpackage

// File: rtl/priv_vec_table.sv
module priv_vec_table #(
  parameter int ENTRIES = 256,
  parameter int VEC_W   = 8,
  parameter int PC_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [VEC_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);
  logic [PC_W-1:0] slot [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (wr_en && wr_idx == VEC_W'(g))
        slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/priv_cause_arb.sv
module priv_cause_arb
  import priv_seq_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int VEC_W       = 8,
  parameter int INSTR_BYTES = 4,
  parameter int PRIV_VEC    = 6,
  parameter int SYSCALL_VEC = 128,
  parameter int IRQ_VEC     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [PC_W-1:0]  instr_pc,
  input  op_e              op,
  input  logic             instr_priv,
  input  logic             fault_valid,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             irq_req,
  input  logic             mode_q,
  input  logic             ie_q,
  output logic             take,
  output cls_e             cls,
  output logic [VEC_W-1:0] vec,
  output logic [PC_W-1:0]  resume_pc,
  output logic             do_setmode,
  output logic             do_setie,
  output logic             do_return
);
  logic is_protected, viol, dfault, trap, intr, exec;

  always_comb begin
    is_protected = instr_priv || op == OP_SETMODE || op == OP_SETIE || op == OP_RETURN;
    viol   = instr_valid && is_protected && mode_q == MODE_USER;
    dfault = instr_valid && fault_valid && !viol;
    trap   = instr_valid && op == OP_SYSCALL && !viol && !fault_valid;
    intr   = instr_valid && irq_req && ie_q && !viol && !fault_valid && op != OP_SYSCALL;
    take   = viol || dfault || trap || intr;
    exec   = instr_valid && !take;

    cls       = CLS_NONE;
    vec       = '0;
    resume_pc = instr_pc;
    if (viol) begin
      cls = CLS_FAULT;
      vec = VEC_W'(PRIV_VEC);
    end else if (dfault) begin
      cls = CLS_FAULT;
      vec = fault_vec;
    end else if (trap) begin
      cls       = CLS_TRAP;
      vec       = VEC_W'(SYSCALL_VEC);
      resume_pc = instr_pc + PC_W'(INSTR_BYTES);
    end else if (intr) begin
      cls = CLS_IRQ;
      vec = VEC_W'(IRQ_VEC);
    end

    do_setmode = exec && op == OP_SETMODE;
    do_setie   = exec && op == OP_SETIE;
    do_return  = exec && op == OP_RETURN;
  end

  // R8: at most one cause wins in a cycle
  assert_single_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({viol, dfault, trap, intr}));

  // R3: a user-mode protected op never reaches execution
  assert_user_no_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USER) |-> !(do_setmode || do_setie || do_return));
endmodule

// File: rtl/priv_mode_state.sv
module priv_mode_state
  import priv_seq_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int VEC_W       = 8,
  parameter int INSTR_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             take,
  input  cls_e             cls,
  input  logic [VEC_W-1:0] vec,
  input  logic [PC_W-1:0]  resume_pc,
  input  logic [PC_W-1:0]  handler_pc,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic             do_setmode,
  input  logic             do_setie,
  input  logic             do_return,
  input  logic             arg,
  output logic             mode_q,
  output logic             ie_q,
  output logic             pend_q,
  output logic             rv_q,
  output logic [PC_W-1:0]  rpc_q,
  output logic [VEC_W-1:0] evec_q,
  output logic [PC_W-1:0]  epc_q,
  output logic             smode_q
);
  logic take_irq;
  assign take_irq = take && cls == CLS_IRQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_KERNEL;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      rv_q    <= 1'b0;
      rpc_q   <= '0;
      evec_q  <= '0;
      epc_q   <= '0;
      smode_q <= MODE_KERNEL;
    end else begin
      pend_q <= (pend_q || irq) && !take_irq;
      rv_q   <= 1'b0;
      if (take) begin
        smode_q <= mode_q;
        mode_q  <= MODE_KERNEL;
        ie_q    <= 1'b0;
        epc_q   <= resume_pc;
        evec_q  <= vec;
        rv_q    <= 1'b1;
        rpc_q   <= handler_pc;
      end else if (do_return) begin
        mode_q <= smode_q;
        rv_q   <= 1'b1;
        rpc_q  <= epc_q;
      end else begin
        if (do_setmode) mode_q <= arg;
        if (do_setie)   ie_q   <= arg;
      end
    end
  end

  // R2: kernel mode is only ever entered by an exception
  assert_no_self_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(take));

  // R4: entry state on the following cycle
  assert_entry_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mode_q && !ie_q && rv_q && smode_q == $past(mode_q) && evec_q == $past(vec)));

  // R5: faults resume at the failing instruction
  assert_fault_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == CLS_FAULT) |=> epc_q == $past(instr_pc));

  // R6: traps resume after the trapping instruction
  assert_trap_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == CLS_TRAP) |=> epc_q == $past(instr_pc) + PC_W'(INSTR_BYTES));

  // R9: a masked request is never lost
  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ie_q) |=> pend_q);

  // R10: return restores the saved mode and targets the saved PC
  assert_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_return |=> (mode_q == $past(smode_q) && rv_q && rpc_q == $past(epc_q)));
endmodule

// File: rtl/priv_exc_seq.sv
module priv_exc_seq
  import priv_seq_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 256,
  parameter int INSTR_BYTES = 4,
  parameter int PRIV_VEC    = 6,
  parameter int SYSCALL_VEC = 128,
  parameter int IRQ_VEC     = 32,
  localparam int VEC_W      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic [2:0]       instr_op,
  input  logic             instr_arg,
  input  logic             instr_priv,
  input  logic             fault_valid,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic             irq,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [VEC_W-1:0] cfg_idx,
  input  logic [PC_W-1:0]  cfg_addr,
  output logic             mode_kernel,
  output logic             irq_en,
  output logic             irq_pending,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [VEC_W-1:0] exc_vec,
  output logic [PC_W-1:0]  epc,
  output logic             saved_mode
);
  logic             mode_q, ie_q, pend_q;
  logic             take, do_setmode, do_setie, do_return;
  cls_e             cls;
  logic [VEC_W-1:0] vec;
  logic [PC_W-1:0]  resume_pc, handler_pc;
  logic             cfg_fire;

  assign cfg_ready = mode_q;
  assign cfg_fire  = cfg_valid && cfg_ready;

  priv_vec_table #(.ENTRIES(ENTRIES), .VEC_W(VEC_W), .PC_W(PC_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_fire), .wr_idx(cfg_idx), .wr_data(cfg_addr),
    .rd_idx(vec), .rd_data(handler_pc)
  );

  priv_cause_arb #(
    .PC_W(PC_W), .VEC_W(VEC_W), .INSTR_BYTES(INSTR_BYTES),
    .PRIV_VEC(PRIV_VEC), .SYSCALL_VEC(SYSCALL_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_pc(instr_pc), .op(op_e'(instr_op)),
    .instr_priv(instr_priv), .fault_valid(fault_valid), .fault_vec(fault_vec),
    .irq_req(pend_q || irq), .mode_q(mode_q), .ie_q(ie_q),
    .take(take), .cls(cls), .vec(vec), .resume_pc(resume_pc),
    .do_setmode(do_setmode), .do_setie(do_setie), .do_return(do_return)
  );

  priv_mode_state #(.PC_W(PC_W), .VEC_W(VEC_W), .INSTR_BYTES(INSTR_BYTES)) u_state (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .take(take), .cls(cls), .vec(vec), .resume_pc(resume_pc),
    .handler_pc(handler_pc), .instr_pc(instr_pc),
    .do_setmode(do_setmode), .do_setie(do_setie), .do_return(do_return),
    .arg(instr_arg),
    .mode_q(mode_q), .ie_q(ie_q), .pend_q(pend_q),
    .rv_q(redirect_valid), .rpc_q(redirect_pc), .evec_q(exc_vec),
    .epc_q(epc), .smode_q(saved_mode)
  );

  assign mode_kernel = mode_q;
  assign irq_en      = ie_q;
  assign irq_pending = pend_q;

  // R11: no table write is accepted from user mode
  assert_cfg_kernel_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !mode_kernel) |-> !cfg_fire);
endmodule

// File: tb/priv_exc_seq_tb.sv
module priv_exc_seq_tb;
  localparam int PC_W = 32;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 0, instr_arg = 0, instr_priv = 0, fault_valid = 0, irq = 0, cfg_valid = 0;
  logic [PC_W-1:0] instr_pc = '0, cfg_addr = '0;
  logic [2:0] instr_op = '0;
  logic [VEC_W-1:0] fault_vec = '0, cfg_idx = '0;
  logic cfg_ready, mode_kernel, irq_en, irq_pending, redirect_valid, saved_mode;
  logic [PC_W-1:0] redirect_pc, epc;
  logic [VEC_W-1:0] exc_vec;

  int checks = 0, failures = 0, cyc_cnt = 0;

  always #2.5 clk = ~clk;

  priv_exc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
    .instr_op(instr_op), .instr_arg(instr_arg), .instr_priv(instr_priv),
    .fault_valid(fault_valid), .fault_vec(fault_vec), .irq(irq),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .mode_kernel(mode_kernel), .irq_en(irq_en), .irq_pending(irq_pending),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_vec(exc_vec),
    .epc(epc), .saved_mode(saved_mode)
  );

  function automatic logic [31:0] tab(int v);
    return 32'h8000_0000 + 32'(v) * 32'd64;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [31:0] pc, input logic [2:0] op, input logic arg,
                       input logic priv, input logic fv, input logic [7:0] fvec, input logic irq_in);
    instr_valid = 1; instr_pc = pc; instr_op = op; instr_arg = arg;
    instr_priv = priv; fault_valid = fv; fault_vec = fvec; irq = irq_in;
    cyc();
    instr_valid = 0; instr_op = 0; instr_arg = 0; instr_priv = 0;
    fault_valid = 0; fault_vec = 0; irq = 0;
  endtask

  task automatic expect_exc(input string req, input int v, input logic [31:0] pc_exp, input logic sm);
    bit ok;
    ok = redirect_valid && redirect_pc == tab(v) && exc_vec == VEC_W'(v) &&
         epc == pc_exp && mode_kernel && !irq_en && saved_mode == sm;
    chk(ok, req, {redirect_pc[23:0], exc_vec}, {tab(v)[23:0], 8'(v)});
    if (ok) chk(epc == pc_exp, req, epc, pc_exp);
  endtask

  task automatic to_user();
    issue(32'h100, 3'd3, 1'b1, 0, 0, 0, 0);
    issue(32'h104, 3'd2, 1'b0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(mode_kernel && !irq_en && !irq_pending && !redirect_valid, "R1",
        {mode_kernel, irq_en, irq_pending, redirect_valid}, 4'b1000);

    // R11 fill table in kernel mode
    chk(cfg_ready, "R11 ready in kernel", cfg_ready, 1);
    for (int i = 0; i < 256; i++) begin
      cfg_valid = 1; cfg_idx = 8'(i); cfg_addr = tab(i);
      cyc();
    end
    cfg_valid = 0;

    // R12, R2
    issue(32'h10, 3'd3, 1'b1, 0, 0, 0, 0);
    chk(irq_en && !redirect_valid, "R12 set ie", irq_en, 1);
    issue(32'h14, 3'd2, 1'b0, 0, 0, 0, 0);
    chk(!mode_kernel && !redirect_valid, "R2 set user", mode_kernel, 0);

    // R11 user write refused
    chk(!cfg_ready, "R11 ready in user", cfg_ready, 0);
    cfg_valid = 1; cfg_idx = 8'd5; cfg_addr = 32'hDEAD_0000;
    cyc();
    cfg_valid = 0;

    // R3 / R2 user set-mode faults
    issue(32'h200, 3'd2, 1'b1, 0, 0, 0, 0);
    expect_exc("R3 user setmode", 6, 32'h200, 1'b0);

    // R10 return
    issue(32'h9000, 3'd4, 1'b0, 0, 0, 0, 0);
    chk(!mode_kernel && redirect_valid && redirect_pc == 32'h200 && !irq_en, "R10 return",
        redirect_pc, 32'h200);

    // R5/R4 sweep of all datapath fault numbers (R11 entry 5 intact)
    for (int v = 0; v < 256; v++) begin
      to_user();
      issue(32'h4000 + 32'(v) * 4, 3'd0, 0, 0, 1'b1, 8'(v), 0);
      expect_exc("R5 fault vector", v, 32'h4000 + 32'(v) * 4, 1'b0);
    end

    // R6 trap from user then from kernel
    to_user();
    issue(32'h5000, 3'd1, 0, 0, 0, 0, 0);
    expect_exc("R6 user syscall", 128, 32'h5004, 1'b0);
    issue(32'h5100, 3'd1, 0, 0, 0, 0, 0);
    expect_exc("R6 kernel syscall", 128, 32'h5104, 1'b1);

    // R3 other protected ops in user
    to_user();
    issue(32'h5200, 3'd3, 1'b0, 0, 0, 0, 0);
    expect_exc("R3 user setie", 6, 32'h5200, 1'b0);
    to_user();
    issue(32'h5300, 3'd4, 0, 0, 0, 0, 0);
    expect_exc("R3 user return", 6, 32'h5300, 1'b0);
    to_user();
    issue(32'h5400, 3'd0, 0, 1'b1, 0, 0, 0);
    expect_exc("R3 user priv flag", 6, 32'h5400, 1'b0);
    issue(32'h5500, 3'd0, 0, 1'b1, 0, 0, 0);
    chk(!redirect_valid && mode_kernel, "R3 kernel priv ok", redirect_valid, 0);

    // R8 fault beats trap and interrupt; R9 interrupt held
    to_user();
    issue(32'h6000, 3'd1, 0, 0, 1'b1, 8'd0, 1'b1);
    expect_exc("R8 fault over trap/irq", 0, 32'h6000, 1'b0);
    chk(irq_pending && !irq_en, "R9 pending masked", irq_pending, 1);
    issue(32'h6080, 3'd0, 0, 0, 0, 0, 0);
    chk(!redirect_valid && irq_pending, "R9 still masked", irq_pending, 1);
    issue(32'h6100, 3'd3, 1'b1, 0, 0, 0, 0);
    chk(irq_en && !redirect_valid, "R12 unmask", irq_en, 1);
    issue(32'h6200, 3'd0, 0, 0, 0, 0, 0);
    expect_exc("R7 pending taken", 32, 32'h6200, 1'b1);
    chk(!irq_pending, "R9 cleared", irq_pending, 0);

    // R8 trap beats interrupt
    to_user();
    issue(32'h6300, 3'd1, 0, 0, 0, 0, 1'b1);
    expect_exc("R8 trap over irq", 128, 32'h6304, 1'b0);
    chk(irq_pending, "R9 pending after trap", irq_pending, 1);
    issue(32'h6400, 3'd3, 1'b1, 0, 0, 0, 0);
    issue(32'h7000, 3'd0, 0, 0, 0, 0, 0);
    expect_exc("R7 irq after unmask", 32, 32'h7000, 1'b1);

    // R7 no instruction presented: not taken
    to_user();
    irq = 1; cyc(); irq = 0;
    chk(!redirect_valid && irq_pending && !mode_kernel, "R7 no instr", irq_pending, 1);
    issue(32'h7100, 3'd0, 0, 0, 0, 0, 0);
    expect_exc("R7 user irq", 32, 32'h7100, 1'b0);

    // R8 privilege fault beats datapath fault
    to_user();
    issue(32'h7200, 3'd2, 1'b1, 0, 1'b1, 8'd3, 0);
    expect_exc("R8 priv over fault", 6, 32'h7200, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule